// File: doc/BRIEF.md
# Interrupt Enable and Status Register Control

This block keeps the processor's 32-bit status word and an 8-bit per-source interrupt enable mask. It executes the interrupt-control commands that a decoder issues to it. The commands cover global enable and disable, masked enable and disable, and selection of one of four interrupt modes. They also move a byte from the accumulator or an immediate into one selected lane of the status word, and copy the low half of the status word into a 16-bit readback register that feeds HL.

A command takes effect on the clock edge where the write strobe is high. The decoder presents a 4-bit command code, the 8-bit operand (accumulator or immediate, already selected upstream) and a 2-bit lane code. Every result is registered and appears on the outputs one cycle after the strobed edge. Interrupt arbitration, vectoring and acknowledge cycles belong to other logic.

Top module: `irq_ctl_sr`

## Requirements
- R1: After reset the status word, the enable mask, the mode and the readback value are all zero.
- R2: Command 1 clears status bit 5, the global enable. Command 2 sets status bit 5. Neither changes the enable mask.
- R3: Command 3 clears each enable-mask bit i whose operand bit i is 1 and keeps the others. It also clears status bit 5 when operand bit 0 is 1, and otherwise leaves status bit 5 as it was.
- R4: Command 4 sets each enable-mask bit i whose operand bit i is 1 and keeps the others. It also sets status bit 5 when operand bit 0 is 1, and otherwise leaves status bit 5 as it was.
- R5: Command 5 loads the interrupt mode from operand bits 1:0, giving modes 0 to 3. It changes neither the status word nor the mask.
- R6: Command 6 loads the operand into one status lane chosen by the lane code: code 1 selects bits 31:24, code 2 selects bits 23:16 and code 3 selects bits 15:8. The other status bits are kept.
- R7: Command 6 with lane code 0 changes nothing. No command ever changes status bits 7:6 or 4:0, which are the flag bits, so they stay zero.
- R8: Command 7 loads status bits 15:0 into the readback output.
- R9: When the strobe is low, or when the strobe is high with command 0 or with any command from 8 to 15, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd | input | 4 | Command code |
| opnd | input | 8 | Operand byte (accumulator or immediate) |
| lane | input | 2 | Status byte-lane select |
| status | output | 32 | Status word |
| ie_mask | output | 8 | Per-source enable mask |
| irq_mode | output | 2 | Current interrupt mode |
| rdback | output | 16 | Readback of status bits 15:0 |

## Verification
The hardest case to reach is a masked command whose operand bit 0 is clear while the global enable is already set or already cleared, because status bit 5 must then keep its earlier value. The stimulus first drives status bit 5 to each value with plain commands and then issues masked operands with bit 0 both set and clear. A long pseudo-random stretch then mixes strobes, unused codes and all lane codes. Throughout, a behavioural model is compared with the outputs on every cycle.

// File: rtl/irq_ctl_sr.sv
module irq_ctl_sr #(
  parameter int SR_W = 32,
  parameter int IE_W = 8,
  parameter int RB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic [3:0]      cmd,
  input  logic [7:0]      opnd,
  input  logic [1:0]      lane,
  output logic [SR_W-1:0] status,
  output logic [IE_W-1:0] ie_mask,
  output logic [1:0]      irq_mode,
  output logic [RB_W-1:0] rdback
);
  localparam int GIE = 5;
  localparam logic [3:0] C_DI   = 4'd1;
  localparam logic [3:0] C_EI   = 4'd2;
  localparam logic [3:0] C_DIM  = 4'd3;
  localparam logic [3:0] C_EIM  = 4'd4;
  localparam logic [3:0] C_MODE = 4'd5;
  localparam logic [3:0] C_SRW  = 4'd6;
  localparam logic [3:0] C_RB   = 4'd7;

  logic [SR_W-1:0] sr_q, sr_d;
  logic [IE_W-1:0] ie_q, ie_d;
  logic [1:0]      md_q, md_d;
  logic [RB_W-1:0] rb_q, rb_d;
  logic [IE_W-1:0] sel;

  assign sel = opnd[IE_W-1:0];

  always_comb begin
    sr_d = sr_q;
    ie_d = ie_q;
    md_d = md_q;
    rb_d = rb_q;
    if (cmd_we) begin
      case (cmd)
        C_DI:   sr_d[GIE] = 1'b0;
        C_EI:   sr_d[GIE] = 1'b1;
        C_DIM: begin
          ie_d = ie_q & ~sel;
          if (opnd[0]) sr_d[GIE] = 1'b0;
        end
        C_EIM: begin
          ie_d = ie_q | sel;
          if (opnd[0]) sr_d[GIE] = 1'b1;
        end
        C_MODE: md_d = opnd[1:0];
        C_SRW: begin
          case (lane)
            2'd1: sr_d[31:24] = opnd;
            2'd2: sr_d[23:16] = opnd;
            2'd3: sr_d[15:8]  = opnd;
            default: ;
          endcase
        end
        C_RB:   rb_d = sr_q[RB_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
      ie_q <= '0;
      md_q <= '0;
      rb_q <= '0;
    end else begin
      sr_q <= sr_d;
      ie_q <= ie_d;
      md_q <= md_d;
      rb_q <= rb_d;
    end
  end

  assign status   = sr_q;
  assign ie_mask  = ie_q;
  assign irq_mode = md_q;
  assign rdback   = rb_q;

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(status) && $stable(ie_mask) && $stable(irq_mode) && $stable(rdback));

  // R7
  flags_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable({status[7:6], status[4:0]}));

  // R2
  gdis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd == C_DI |=> !status[GIE] && $stable(ie_mask));

  // R3
  mdis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd == C_DIM |=> (ie_mask & $past(opnd)) == 8'h00);

  // R4
  mena_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd == C_EIM |=> (ie_mask & $past(opnd)) == $past(opnd));

  // R6
  lane_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd == C_SRW && lane == 2'd1 |=> status[31:24] == $past(opnd));

  // R5
  mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd == C_MODE |=> irq_mode == $past(opnd[1:0]) && $stable(status));
endmodule

// File: tb/irq_ctl_sr_bench.sv
module irq_ctl_sr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [3:0]  cmd = '0;
  logic [7:0]  opnd = '0;
  logic [1:0]  lane = '0;
  logic [31:0] status;
  logic [7:0]  ie_mask;
  logic [1:0]  irq_mode;
  logic [15:0] rdback;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_sr;
  logic [7:0]  m_ie;
  logic [1:0]  m_md;
  logic [15:0] m_rb;

  always #4 clk = ~clk;

  irq_ctl_sr u_irq_ctl_sr (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd), .opnd(opnd), .lane(lane),
    .status(status), .ie_mask(ie_mask), .irq_mode(irq_mode), .rdback(rdback)
  );

  task automatic compare(input string tag);
    checks++;
    if (status !== m_sr || ie_mask !== m_ie || irq_mode !== m_md || rdback !== m_rb) begin
      errors++;
      $display("FAIL %s: got sr=%h ie=%h md=%0d rb=%h exp sr=%h ie=%h md=%0d rb=%h",
               tag, status, ie_mask, irq_mode, rdback, m_sr, m_ie, m_md, m_rb);
    end
  endtask

  task automatic model(input bit we, input int c, input int o, input int l);
    logic [31:0] s;
    logic [7:0]  ob;
    s = m_sr;
    ob = o[7:0];
    if (!we) return;
    if (c == 1) s[5] = 0;
    else if (c == 2) s[5] = 1;
    else if (c == 3) begin
      m_ie = m_ie & ~ob;
      if (ob[0]) s[5] = 0;
    end else if (c == 4) begin
      m_ie = m_ie | ob;
      if (ob[0]) s[5] = 1;
    end else if (c == 5) m_md = ob[1:0];
    else if (c == 6) begin
      if (l == 1) s[31:24] = ob;
      else if (l == 2) s[23:16] = ob;
      else if (l == 3) s[15:8] = ob;
    end else if (c == 7) m_rb = m_sr[15:0];
    m_sr = s;
  endtask

  task automatic step(input bit we, input int c, input int o, input int l, input string tag);
    cmd_we = we;
    cmd = c[3:0];
    opnd = o[7:0];
    lane = l[1:0];
    @(posedge clk);
    model(we, c, o, l);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    m_sr = '0; m_ie = '0; m_md = '0; m_rb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset");
    // R2 plain enable then disable
    step(1, 2, 0, 0, "R2 enable");
    step(1, 4, 8'hF0, 0, "R4 mask set no gie");
    step(1, 1, 0, 0, "R2 disable");
    // R4 masked enable with bit 0 set
    step(1, 4, 8'hA5, 0, "R4 mask set gie");
    // R3 masked disable bit0 clear keeps gie
    step(1, 3, 8'h24, 0, "R3 mask clr keep gie");
    step(1, 3, 8'h01, 0, "R3 mask clr gie");
    step(1, 4, 8'h02, 0, "R4 bit0 clear keeps gie low");
    // R5 modes
    for (int k = 0; k < 4; k++) step(1, 5, 8'hFC | k, 0, "R5 mode");
    // R6 lanes
    step(1, 6, 8'h9A, 1, "R6 lane1");
    step(1, 6, 8'h3C, 2, "R6 lane2");
    step(1, 6, 8'hFF, 3, "R6 lane3");
    // R7 lane 0 ignored
    step(1, 6, 8'h55, 0, "R7 lane0");
    step(1, 2, 0, 0, "R2 enable again");
    // R8 readback
    step(1, 7, 0, 0, "R8 readback");
    // R9 no strobe, unused codes
    step(0, 6, 8'h11, 1, "R9 no strobe");
    step(0, 1, 0, 0, "R9 no strobe di");
    step(1, 0, 8'hFF, 1, "R9 cmd0");
    step(1, 12, 8'hFF, 2, "R9 cmd12");
    step(1, 15, 8'hFF, 3, "R9 cmd15");
    seed = 32'h1234;
    for (int i = 0; i < 400; i++) begin
      int r;
      seed = seed * 1103515245 + 12345;
      r = seed >>> 8;
      step(r[0] | r[1], r[5:2] & 4'hF, r[13:6], r[15:14], "R7 random mix");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule